// File: doc/BRIEF.md
# I2C Slave Transmitter with Status Codes

This block is the transmit half of an I2C-compatible slave. It watches the serial clock and data lines through a synchronizer and spots START and STOP conditions. When a master reads from the block's own 7-bit address, the block acknowledges and then shifts data bytes out MSB first. The block drives both lines as open-drain pull-downs.

At each protocol milestone the block raises an interrupt flag, posts a fixed one-byte status code and stretches SCL low until the host clears the flag. The host supplies each outgoing byte on a valid/ready stream while the flag is up. The byte is accepted on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while the block waits for the next byte and holds none. If the host clears the flag without offering a byte, the block sends 8'hFF. `tx_data` must stay stable while `tx_valid` is high and `tx_ready` is low.

The host can take the block off the bus with an acknowledge-enable level. A START or STOP in the middle of a byte or an acknowledge slot is treated as a bus error, which the host recovers from with a stop request. A lost-arbitration pulse is an extra way into transmitter operation.

Top module: `i2c_stx_top`

## Requirements
- R1: After reset `status` reads 8'hF8, and `irq`, `scl_oe`, `sda_oe`, `stop_pend` and `tx_ready` are all 0.
- R2: A byte that follows START is acknowledged only if it carries the own address in bits 7..1 and a 1 (read) in bit 0, and `ack_en` is 1. The block pulls SDA low during the ninth clock. After the ninth falling edge it sets `irq`, reports 8'hA8, and holds SCL low while `irq` is set.
- R3: An address byte with another address, or with bit 0 equal to 0, gets no acknowledge and sets no flag.
- R4: Data bytes leave MSB first. Each bit changes only while SCL is low. `tx_ready` is high only while the flag is up and a byte is awaited. With no byte offered, 8'hFF is sent.
- R5: When the master acknowledges a byte that is not final, the status is 8'hB8 and the block waits for the next byte.
- R6: When the master does not acknowledge a byte, the status is 8'hC0. Once the flag is cleared the block is non-addressed and leaves SDA released, so further reads return all ones.
- R7: The value of `ack_en` in the cycle the flag is cleared decides whether the byte being loaded is final. If `ack_en` is 0, that byte is sent, and an acknowledge from the master then gives 8'hC8, after which the block is non-addressed and SDA stays released.
- R8: While `ack_en` is 0 the own address is not acknowledged. Setting `ack_en` back to 1 restores recognition for the next START.
- R9: `status` reads 8'hF8 whenever `irq` is 0, and never reads 8'hF8 while `irq` is 1.
- R10: A START or STOP seen after the first address bit, during a data byte, or during an acknowledge slot sets `irq`, reports 8'h00, releases SDA and holds SCL low.
- R11: `stop_set` is taken only in the bus-error state. Once the stop request is pending and the flag is clear, the block returns to idle, clears `stop_pend` itself, releases both lines, and drives no STOP.
- R12: A `arb_lost` pulse while idle sets `irq`, reports 8'hB0 and enters transmitter operation with SCL held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr | input | 7 | Own slave address |
| ack_en | input | 1 | Acknowledge enable level |
| stop_set | input | 1 | Pulse: request bus-error recovery |
| flag_clr | input | 1 | Pulse: clear the interrupt flag |
| arb_lost | input | 1 | Pulse: enter transmitter operation as if arbitration was lost |
| irq | output | 1 | Interrupt flag |
| status | output | 8 | Status code |
| stop_pend | output | 1 | Stop request pending |
| tx_data | input | 8 | Next byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block accepts a byte |

## Verification
Two events can land in the same cycle here. The first is the host dropping `ack_en` in the very cycle it clears the flag that releases the next byte. The bench drives both on one edge and judges by the status that follows the master's acknowledge (8'hC8, not 8'hB8) and by the all-ones read after it. The second is a `stop_set` and `flag_clr` pulse issued together in the bus-error state. The bench expects `stop_pend` high exactly one cycle later, and on the cycle after that it expects both line drivers off and the pending bit gone.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [BYTE_W-1:0] ST_NONE  = 8'hF8;
  localparam logic [BYTE_W-1:0] ST_BERR  = 8'h00;
  localparam logic [BYTE_W-1:0] ST_ADDR  = 8'hA8;
  localparam logic [BYTE_W-1:0] ST_ARB   = 8'hB0;
  localparam logic [BYTE_W-1:0] ST_ACKED = 8'hB8;
  localparam logic [BYTE_W-1:0] ST_NACK  = 8'hC0;
  localparam logic [BYTE_W-1:0] ST_LAST  = 8'hC8;
  localparam logic [BYTE_W-1:0] FILL     = 8'hFF;

  typedef enum logic [2:0] {
    P_IDLE, P_ADR, P_ADR_ACK, P_HOLD, P_SEND, P_SEND_ACK, P_BERR
  } phase_t;
endpackage

// File: rtl/i2c_stx_linemon.sv
module i2c_stx_linemon #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  generate
    if (SYNC_N == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_q <= '1; sda_q <= '1; end
        else begin scl_q <= scl_i; sda_q <= sda_i; end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_q <= '1; sda_q <= '1; end
        else begin
          scl_q <= {scl_q[SYNC_N-2:0], scl_i};
          sda_q <= {sda_q[SYNC_N-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_s = scl_q[SYNC_N-1];
  assign sda_s = sda_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_p <= 1'b1; sda_p <= 1'b1; end
    else begin scl_p <= scl_s; sda_p <= sda_s; end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_stx_txbuf.sv
module i2c_stx_txbuf
  import i2c_stx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_take,
  input  logic              take,
  output logic              have,
  output logic [BYTE_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      have <= 1'b0;
      data <= '0;
    end else if (in_take) begin
      have <= 1'b1;
      data <= in_data;
    end else if (take) begin
      have <= 1'b0;
    end
endmodule

// File: rtl/i2c_stx_ctrl.sv
module i2c_stx_ctrl
  import i2c_stx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADR_W-1:0]  own_addr,
  input  logic              ack_en,
  input  logic              stop_set,
  input  logic              flag_clr,
  input  logic              arb_lost,
  input  logic              buf_have,
  input  logic [BYTE_W-1:0] buf_data,
  output logic              buf_take,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq,
  output logic [BYTE_W-1:0] status,
  output logic              stop_pend,
  output logic              tx_ready
);
  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              half, last, mack, flag, hold_tx, stop_b, sda_low;
  logic [BYTE_W-1:0] code;
  logic [BYTE_W-1:0] rx_byte, load;
  logic              cond;

  assign rx_byte  = {sh[BYTE_W-2:0], sda_s};
  assign load     = buf_have ? buf_data : FILL;
  assign cond     = start_det | stop_det;
  assign buf_take = (ph == P_HOLD) && !flag && hold_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_IDLE; cnt <= '0; sh <= '0; half <= 1'b0; last <= 1'b0;
      mack <= 1'b0; flag <= 1'b0; hold_tx <= 1'b0; stop_b <= 1'b0;
      sda_low <= 1'b0; code <= ST_NONE;
    end else begin
      if (flag_clr) flag <= 1'b0;
      if (stop_set && ph == P_BERR) stop_b <= 1'b1;
      case (ph)
        P_IDLE: begin
          if (start_det) begin
            ph <= P_ADR; cnt <= '0;
          end else if (arb_lost) begin
            ph <= P_HOLD; flag <= 1'b1; code <= ST_ARB; hold_tx <= 1'b1;
          end
        end
        P_ADR: begin
          if (cond && cnt != '0) begin
            ph <= P_BERR; flag <= 1'b1; code <= ST_BERR; sda_low <= 1'b0;
          end else if (start_det) begin
            cnt <= '0;
          end else if (stop_det) begin
            ph <= P_IDLE;
          end else if (scl_rise) begin
            sh  <= rx_byte;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(BYTE_W - 1)) begin
              if (ack_en && rx_byte[BYTE_W-1:1] == own_addr && rx_byte[0]) begin
                ph <= P_ADR_ACK; half <= 1'b0;
              end else begin
                ph <= P_IDLE;
              end
            end
          end
        end
        P_ADR_ACK: begin
          if (cond) begin
            ph <= P_BERR; flag <= 1'b1; code <= ST_BERR; sda_low <= 1'b0;
          end else if (scl_fall) begin
            if (!half) begin
              sda_low <= 1'b1; half <= 1'b1;
            end else begin
              sda_low <= 1'b0; flag <= 1'b1; code <= ST_ADDR;
              hold_tx <= 1'b1; ph <= P_HOLD;
            end
          end
        end
        P_HOLD: begin
          if (!flag) begin
            if (hold_tx) begin
              sh <= load; last <= !ack_en; sda_low <= !load[BYTE_W-1];
              cnt <= '0; ph <= P_SEND;
            end else begin
              ph <= P_IDLE;
            end
          end
        end
        P_SEND: begin
          if (cond) begin
            ph <= P_BERR; flag <= 1'b1; code <= ST_BERR; sda_low <= 1'b0;
          end else if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt != '0) begin
            if (cnt == CNT_W'(BYTE_W)) begin
              sda_low <= 1'b0; half <= 1'b0; ph <= P_SEND_ACK;
            end else begin
              sh <= sh << 1; sda_low <= !sh[BYTE_W-2];
            end
          end
        end
        P_SEND_ACK: begin
          if (cond) begin
            ph <= P_BERR; flag <= 1'b1; code <= ST_BERR; sda_low <= 1'b0;
          end else if (scl_rise) begin
            half <= 1'b1; mack <= !sda_s;
          end else if (scl_fall && half) begin
            flag <= 1'b1;
            code <= !mack ? ST_NACK : (last ? ST_LAST : ST_ACKED);
            hold_tx <= mack && !last;
            ph <= P_HOLD;
          end
        end
        P_BERR: begin
          if (stop_b && !flag) begin
            stop_b <= 1'b0; ph <= P_IDLE;
          end
        end
        default: ph <= P_IDLE;
      endcase
    end
  end

  assign scl_oe    = (ph == P_HOLD) || (ph == P_BERR);
  assign sda_oe    = sda_low;
  assign irq       = flag;
  assign status    = flag ? code : ST_NONE;
  assign stop_pend = stop_b;
  assign tx_ready  = (ph == P_HOLD) && flag && hold_tx && !buf_have;
endmodule

// File: rtl/i2c_stx_top.sv
module i2c_stx_top
  import i2c_stx_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADR_W-1:0]  own_addr,
  input  logic              ack_en,
  input  logic              stop_set,
  input  logic              flag_clr,
  input  logic              arb_lost,
  output logic              irq,
  output logic [BYTE_W-1:0] status,
  output logic              stop_pend,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic buf_have, buf_take;
  logic [BYTE_W-1:0] buf_data;

  i2c_stx_linemon #(.SYNC_N(SYNC_N)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_stx_txbuf u_buf (
    .clk(clk), .rst_n(rst_n), .in_data(tx_data), .in_take(tx_valid && tx_ready),
    .take(buf_take), .have(buf_have), .data(buf_data)
  );

  i2c_stx_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .ack_en(ack_en), .stop_set(stop_set),
    .flag_clr(flag_clr), .arb_lost(arb_lost), .buf_have(buf_have),
    .buf_data(buf_data), .buf_take(buf_take), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .irq(irq), .status(status), .stop_pend(stop_pend),
    .tx_ready(tx_ready)
  );
endmodule

// File: rtl/i2c_stx_chk.sv
module i2c_stx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq,
  input logic [7:0] status,
  input logic       stop_pend,
  input logic       tx_ready
);
  AST_SCL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_oe); // R2
  AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || irq)); // R4
  AST_READY_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> irq); // R4
  AST_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status != 8'hF8); // R9
  AST_BERR_SDA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && status == 8'h00) |-> !sda_oe); // R10
  AST_RECOVER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_pend) |-> (!scl_oe && !sda_oe)); // R11
endmodule

bind i2c_stx_top i2c_stx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .status(status), .stop_pend(stop_pend), .tx_ready(tx_ready)
);

// File: tb/sim_i2c_stx_top.sv
module sim_i2c_stx_top;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic ack_en = 1'b1, stop_set = 1'b0, flag_clr = 1'b0, arb_lost = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic scl_oe, sda_oe, irq, stop_pend, tx_ready;
  logic [7:0] status;
  wire scl_line = !(m_scl_lo | scl_oe);
  wire sda_line = !(m_sda_lo | sda_oe);

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_stx_top u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .ack_en(ack_en),
    .stop_set(stop_set), .flag_clr(flag_clr), .arb_lost(arb_lost),
    .irq(irq), .status(status), .stop_pend(stop_pend),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      finish_up();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_line) tick(1);
  endtask

  task automatic m_start();
    m_sda_lo = 0; m_scl_lo = 0; tick(Q);
    m_sda_lo = 1; tick(Q);
    m_scl_lo = 1; tick(Q);
  endtask

  task automatic m_stop();
    m_sda_lo = 1; tick(Q);
    m_scl_lo = 0; wait_high(); tick(Q);
    m_sda_lo = 0; tick(Q);
  endtask

  task automatic m_wbit(input logic b);
    m_sda_lo = !b; tick(Q);
    m_scl_lo = 0; wait_high(); tick(Q);
    m_scl_lo = 1; tick(Q);
  endtask

  task automatic m_rbit(output logic b);
    m_sda_lo = 0; tick(Q);
    m_scl_lo = 0; wait_high(); tick(Q/2);
    b = sda_line; tick(Q/2);
    m_scl_lo = 1; tick(Q);
  endtask

  task automatic m_addr(input logic [6:0] a, input logic rw, output logic acked);
    logic b;
    for (int i = 6; i >= 0; i--) m_wbit(a[i]);
    m_wbit(rw);
    m_rbit(b);
    acked = !b;
  endtask

  task automatic m_rbyte(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_rbit(b); d[i] = b; end
  endtask

  task automatic push(input logic [7:0] d);
    while (!tx_ready) tick(1);
    tx_data = d; tx_valid = 1; tick(1); tx_valid = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; tick(1); flag_clr = 0; tick(1);
  endtask

  initial begin
    logic acked;
    logic [7:0] d;
    tick(3);
    // R1 reset state
    chk("R1 status", status, 8'hF8);
    chk("R1 outputs", {irq, scl_oe, sda_oe, stop_pend, tx_ready}, 0);
    rst_n = 1; tick(4);

    // R3 sweep: every address with write bit, every foreign address with read bit
    for (int rw = 0; rw < 2; rw++) begin
      for (int a = 0; a < 128; a++) begin
        if (rw == 1 && a == OWN) continue;
        m_start(); m_addr(7'(a), 1'(rw), acked);
        chk("R3 no ack", acked, 0);
        chk("R3 no flag", irq, 0);
        m_stop();
      end
    end

    // R2 own address read
    m_start(); m_addr(OWN, 1, acked);
    chk("R2 ack", acked, 1);
    chk("R2 flag", irq, 1);
    chk("R2 status", status, 8'hA8);
    chk("R2 scl held", scl_line, 0);
    chk("R4 ready", tx_ready, 1);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] exp_b;
      exp_b = (i == 2) ? 8'hFF : 8'((i * 83 + 29) ^ (i << 6));
      if (i != 2) push(exp_b);
      clear_flag();
      chk("R9 idle code", status, 8'hF8);
      m_rbyte(d);
      chk("R4 data", d, exp_b);
      m_wbit(i == 3);
      chk("R5/R6 flag", irq, 1);
      chk(i == 3 ? "R6 nack code" : "R5 ack code", status, i == 3 ? 8'hC0 : 8'hB8);
    end
    clear_flag();
    m_rbyte(d);
    chk("R6 all ones", d, 8'hFF);
    chk("R6 no flag", irq, 0);
    m_rbit(acked); m_stop();

    // R7 ack_en dropped in the same cycle as the flag clear
    m_start(); m_addr(OWN, 1, acked);
    chk("R7 addr ack", acked, 1);
    push(8'hC3);
    ack_en = 0; flag_clr = 1; tick(1); flag_clr = 0; tick(1);
    m_rbyte(d);
    chk("R7 final byte", d, 8'hC3);
    m_wbit(0);
    chk("R7 code", status, 8'hC8);
    clear_flag();
    m_rbyte(d);
    chk("R7 detached ones", d, 8'hFF);
    chk("R7 no flag", irq, 0);
    m_rbit(acked); m_stop();

    // R8 own address ignored while ack_en is 0, then restored
    m_start(); m_addr(OWN, 1, acked);
    chk("R8 ignored", {acked, irq}, 0);
    m_stop();
    ack_en = 1;
    m_start(); m_addr(OWN, 1, acked);
    chk("R8 restored", {acked, irq}, 2'b11);
    clear_flag();
    m_rbyte(d);
    chk("R4 fill byte", d, 8'hFF);
    m_wbit(1);
    chk("R6 code", status, 8'hC0);
    clear_flag(); m_stop();

    // R10 STOP inside an address byte, R11 recovery
    m_start(); m_wbit(1); m_wbit(0); m_wbit(1);
    m_stop(); tick(Q);
    chk("R10 flag", irq, 1);
    chk("R10 code", status, 8'h00);
    chk("R10 lines", {scl_line, sda_oe}, 0);
    clear_flag(); tick(Q);
    chk("R11 no stop no exit", {irq, scl_oe}, 2'b01);
    chk("R9 after clear", status, 8'hF8);
    stop_set = 1; tick(1); stop_set = 0;
    chk("R11 pending", stop_pend, 1);
    tick(1);
    chk("R11 released", {stop_pend, scl_oe, sda_oe}, 0);

    // R10 START inside a data byte; recovery with both pulses together
    m_start(); m_addr(OWN, 1, acked);
    clear_flag();
    m_rbit(acked); m_rbit(acked);
    m_sda_lo = 0; tick(Q); m_scl_lo = 0; wait_high(); tick(Q);
    m_sda_lo = 1; tick(Q);
    chk("R10 start code", {irq, status}, 9'h100);
    stop_set = 1; flag_clr = 1; tick(1); stop_set = 0; flag_clr = 0;
    chk("R11 pending joint", stop_pend, 1);
    tick(1);
    chk("R11 joint release", {stop_pend, scl_oe, sda_oe, irq}, 0);
    m_sda_lo = 0; tick(Q);

    // R12 lost-arbitration entry
    m_scl_lo = 1; tick(Q);
    arb_lost = 1; tick(1); arb_lost = 0; tick(1);
    chk("R12 code", {irq, status}, 9'h1B0);
    push(8'hA5); clear_flag();
    m_rbyte(d);
    chk("R12 data", d, 8'hA5);
    m_wbit(1);
    chk("R12 nack code", status, 8'hC0);
    clear_flag();
    m_sda_lo = 0; m_scl_lo = 0; tick(Q);
    chk("R12 idle", {irq, scl_oe, sda_oe}, 0);

    finish_up();
  end
endmodule